// File: doc/BRIEF.md
# Serial Flash Read-Command Front End

This block is the serial slave side of a page-organised flash memory, limited to reads. A host selects the device by pulling chip select low. It then clocks in an 8-bit command code and a 24-bit address, and reads data back on the serial output. Three read commands exist. One is a continuous read of the main array. The other two read one of two page-sized staging buffers. The block turns each command into a sequence of one-byte requests on a synchronous read port. A behavioural store of the array and the buffers sits behind that port.

A page holds 264 bytes, which is not a power of two. The address is therefore split into an 11-bit page number and a 9-bit byte offset. Once a start address is loaded, the block's own counter walks the offset forward one byte per byte shifted out. It folds back from offset 263 to zero and carries into the page number. The host only keeps the serial clock running.

The serial pins are oversampled on the system clock, which must run at least six times faster than the serial clock. Both common clock phases are accepted: clock idling low and clock idling high. In both, input is captured on the rising edge and output is launched on the falling edge.

Top module: `spi_flash_read_front`

## Requirements
- R1: After reset, and whenever chip select is high, `so_oe` is low and `mem_rd` stays low.
- R2: The first 8 bits after chip select falls form the command code, captured MSB first on rising serial clock edges. Code 0xA1 reads the main array (`mem_src` = 0). Code 0xB1 reads buffer A (`mem_src` = 1). Code 0xB2 reads buffer B (`mem_src` = 2).
- R3: The 24 address bits that follow are captured MSB first. Bits [19:9] give the page number and bits [8:0] give the byte offset. Bits [23:20] have no effect on the data returned.
- R4: A main-array read takes 8 don't-care bits after the address. The first data bit appears on the first falling serial clock edge after the last of those bits. Data bits follow MSB first, one per falling edge.
- R5: A buffer read has no don't-care bits. Data starts on the first falling edge after the last address bit, beginning at the addressed offset of the selected buffer.
- R6: During a main-array read the offset advances by one per byte. When the offset of the byte just sent is 263 or higher, the next offset is 0 and the page number increments, with page 2047 followed by page 0.
- R7: During a buffer read the offset advances by one per byte and returns from 263 to 0.
- R8: Hosts using the idle-low clock and hosts using the idle-high clock receive identical data. A falling edge that comes before the first rising edge of a command is ignored.
- R9: `so_oe` is low through the command, address and don't-care bits. It is high on every data bit while chip select is low.
- R10: A rising chip select at any bit position aborts the command and releases `so_oe`. The next command is decoded from its first bit.
- R11: Any other command code causes no memory request and no output drive until chip select goes high.
- R12: Each byte is fetched by a single-cycle `mem_rd` pulse. `mem_rdata` is taken in the following clock cycle. A read of N complete bytes issues exactly N+1 requests, because the next byte is prefetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for the `so` pad driver |
| mem_rd | output | 1 | One-cycle read request to the store |
| mem_src | output | 2 | Source: 0 = array, 1 = buffer A, 2 = buffer B |
| mem_page | output | 11 | Page number (array reads only) |
| mem_byte | output | 9 | Byte offset within the page or buffer |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |

## Verification
The hardest states to reach are the boundary steps of the internal counter: the offset folding from 263 to 0, the page number passing from 2047 to 0, and a start offset beyond the last byte. Reaching them from the pins takes a long stream. The bench gets there with directed start addresses placed just before the boundaries, so a few bytes cross them. Random commands, clock phases, upper address bits and stream lengths run in between. Aborts are forced in the middle of the address and in the middle of a data byte. A clean command follows each abort to show that decoding restarts from bit zero.

// File: rtl/spi_flash_read_front.sv
module spi_flash_read_front #(
  parameter int PAGE_BITS  = 11,
  parameter int BYTE_BITS  = 9,
  parameter int PAGE_BYTES = 264,
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_BITS = 8,
  parameter logic [7:0] OP_ARRAY = 8'hA1,
  parameter logic [7:0] OP_BUF_A = 8'hB1,
  parameter logic [7:0] OP_BUF_B = 8'hB2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sck,
  input  logic                 si,
  output logic                 so,
  output logic                 so_oe,
  output logic                 mem_rd,
  output logic [1:0]           mem_src,
  output logic [PAGE_BITS-1:0] mem_page,
  output logic [BYTE_BITS-1:0] mem_byte,
  input  logic [7:0]           mem_rdata
);

  localparam int FIELD_BITS = PAGE_BITS + BYTE_BITS;
  localparam int CW = $clog2(ADDR_BITS + DUMMY_BITS + 8);
  localparam logic [CW-1:0] OP_LAST   = CW'(7);
  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_BITS - 1);
  localparam logic [CW-1:0] DUM_LAST  = CW'(DUMMY_BITS > 0 ? DUMMY_BITS - 1 : 0);
  localparam logic [BYTE_BITS-1:0] BYTE_LAST = BYTE_BITS'(PAGE_BYTES - 1);
  localparam logic [1:0] SRC_ARRAY = 2'd0;
  localparam logic [1:0] SRC_BUF_A = 2'd1;
  localparam logic [1:0] SRC_BUF_B = 2'd2;

  typedef enum logic [2:0] {S_OP, S_ADDR, S_DUMMY, S_DATA, S_IGN} st_t;

  logic [2:0] sck_q;
  logic [1:0] si_q, cs_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      si_q  <= '0;
      cs_q  <= 2'b11;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      si_q  <= {si_q[0], si};
      cs_q  <= {cs_q[0], cs_n};
    end

  wire cs_idle  = cs_q[1];
  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire si_s     = si_q[1];

  st_t                  st;
  logic [CW-1:0]        cnt;
  logic [6:0]           op_sh;
  logic [FIELD_BITS-1:0] a_sh;
  logic [PAGE_BITS-1:0] page_q;
  logic [BYTE_BITS-1:0] byte_q;
  logic [1:0]           src_q;
  logic [7:0]           out_sh;
  logic [2:0]           bcnt;
  logic                 so_q, oe_q, fetch_q, load_q;

  wire [7:0]            op_word   = {op_sh, si_s};
  wire [FIELD_BITS-1:0] addr_word = {a_sh[FIELD_BITS-2:0], si_s};
  wire                  at_last   = (byte_q >= BYTE_LAST);
  wire [BYTE_BITS-1:0]  byte_inc  = at_last ? '0 : byte_q + 1'b1;
  wire [PAGE_BITS-1:0]  page_inc  = (at_last && src_q == SRC_ARRAY) ? page_q + 1'b1 : page_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_OP;  cnt <= '0;  op_sh <= '0;  a_sh <= '0;
      page_q <= '0;  byte_q <= '0;  src_q <= SRC_ARRAY;
      out_sh <= '0;  bcnt <= '0;  so_q <= 1'b0;  oe_q <= 1'b0;
      fetch_q <= 1'b0;  load_q <= 1'b0;
    end else if (cs_idle) begin
      st <= S_OP;  cnt <= '0;  bcnt <= '0;
      oe_q <= 1'b0;  fetch_q <= 1'b0;  load_q <= 1'b0;
    end else begin
      fetch_q <= 1'b0;
      load_q  <= fetch_q;
      if (load_q) out_sh <= mem_rdata;
      case (st)
        S_OP: if (sck_rise) begin
          op_sh <= op_word[6:0];
          cnt   <= cnt + 1'b1;
          if (cnt == OP_LAST) begin
            cnt <= '0;
            if (op_word == OP_ARRAY)      begin src_q <= SRC_ARRAY; st <= S_ADDR; end
            else if (op_word == OP_BUF_A) begin src_q <= SRC_BUF_A; st <= S_ADDR; end
            else if (op_word == OP_BUF_B) begin src_q <= SRC_BUF_B; st <= S_ADDR; end
            else st <= S_IGN;
          end
        end
        S_ADDR: if (sck_rise) begin
          a_sh <= addr_word;
          cnt  <= cnt + 1'b1;
          if (cnt == ADDR_LAST) begin
            cnt    <= '0;
            page_q <= addr_word[FIELD_BITS-1:BYTE_BITS];
            byte_q <= addr_word[BYTE_BITS-1:0];
            if (src_q == SRC_ARRAY && DUMMY_BITS > 0) st <= S_DUMMY;
            else begin st <= S_DATA; fetch_q <= 1'b1; end
          end
        end
        S_DUMMY: if (sck_rise) begin
          cnt <= cnt + 1'b1;
          if (cnt == DUM_LAST) begin
            cnt <= '0;  st <= S_DATA;  fetch_q <= 1'b1;
          end
        end
        S_DATA: if (sck_fall) begin
          so_q   <= out_sh[7];
          out_sh <= {out_sh[6:0], 1'b0};
          oe_q   <= 1'b1;
          bcnt   <= bcnt + 1'b1;
          if (bcnt == 3'd7) begin
            page_q  <= page_inc;
            byte_q  <= byte_inc;
            fetch_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end

  assign so       = so_q;
  assign so_oe    = oe_q & ~cs_n;
  assign mem_rd   = fetch_q;
  assign mem_src  = src_q;
  assign mem_page = page_q;
  assign mem_byte = byte_q;

  assert_quiet_when_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (!oe_q && !mem_rd));

  assert_single_cycle_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  assert_drive_only_in_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> st == S_DATA);

  assert_unknown_code_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IGN |-> (!mem_rd && !oe_q));

  assert_offset_in_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(st) == S_DATA) |-> mem_byte <= BYTE_LAST);

  assert_output_holds_between_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && !sck_fall && !cs_idle) |=> $stable(so_q));

endmodule

// File: tb/tb_spi_flash_read_front.sv
module tb_spi_flash_read_front;
  localparam int H = 4;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0;
  logic so, so_oe, mem_rd;
  logic [1:0] mem_src;
  logic [10:0] mem_page;
  logic [8:0] mem_byte;
  logic [7:0] mem_rdata = '0;

  int tests = 0, fails = 0, rd_cnt = 0, cmd_oe_seen = 0;
  bit done = 0, in_data = 0, mode3 = 0;
  logic last_so, last_oe;

  spi_flash_read_front dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe),
    .mem_rd(mem_rd), .mem_src(mem_src), .mem_page(mem_page), .mem_byte(mem_byte),
    .mem_rdata(mem_rdata));

  always #2 clk = ~clk;

  function automatic logic [7:0] mval(input int s, input int pg, input int off);
    case (s)
      0:       return 8'((pg * 37 + off * 11 + (pg >> 4)) ^ 'h96);
      1:       return 8'((off * 3) ^ 'hC5);
      default: return 8'(off * 7 + 'h2B);
    endcase
  endfunction

  always @(posedge clk)
    if (mem_rd) begin
      mem_rdata <= mval(int'(mem_src), int'(mem_page), int'(mem_byte));
      rd_cnt++;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    sck = 0;  si = b;
    repeat (H) @(negedge clk);
    last_so = so;  last_oe = so_oe;
    if (so_oe && !in_data) cmd_oe_seen++;
    sck = 1;
    repeat (H) @(negedge clk);
  endtask

  task automatic begin_cmd(input bit m3);
    mode3 = m3;  sck = m3;
    repeat (4) @(negedge clk);
    cs_n = 0;  in_data = 0;  cmd_oe_seen = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic end_cmd();
    if (!mode3) sck = 0;
    repeat (H) @(negedge clk);
    cs_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
  endtask

  task automatic do_read(input bit m3, input logic [7:0] op, input int pg0, input int off0,
                         input logic [3:0] upper, input int n, input string req);
    int s, pg, off, r0;
    logic [7:0] b;
    bit oe_ok;
    s = (op == 8'hA1) ? 0 : (op == 8'hB1) ? 1 : 2;
    pg = pg0;  off = off0;  r0 = rd_cnt;
    begin_cmd(m3);
    send({24'd0, op}, 8);
    send({8'd0, upper, pg0[10:0], off0[8:0]}, 24);
    if (s == 0) send($urandom, 8);
    chk(cmd_oe_seen == 0, "R9 drive during command", cmd_oe_seen, 0);
    in_data = 1;
    for (int k = 0; k < n; k++) begin
      oe_ok = 1;
      for (int i = 7; i >= 0; i--) begin
        clk_bit(1'($urandom));
        b[i] = last_so;
        if (!last_oe) oe_ok = 0;
      end
      chk(b == mval(s, pg, off), req, b, mval(s, pg, off));
      chk(oe_ok, "R9 drive during data", oe_ok, 1);
      if (off >= 263) begin
        off = 0;
        if (s == 0) pg = (pg + 1) % 2048;
      end else off++;
    end
    end_cmd();
    in_data = 0;
    chk(rd_cnt - r0 == n + 1, "R12 request count", rd_cnt - r0, n + 1);
    chk(so_oe == 0, "R1 release after command", so_oe, 0);
  endtask

  initial begin
    int r0;
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    chk(so_oe == 0 && mem_rd == 0, "R1 reset state", {so_oe, mem_rd}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(so_oe == 0 && mem_rd == 0, "R1 idle after reset", {so_oe, mem_rd}, 0);

    do_read(0, 8'hA1, 5, 0, 4'h0, 3, "R4 array read");
    do_read(0, 8'hA1, 1234, 77, 4'hF, 2, "R3 upper bits");
    do_read(0, 8'hB1, 0, 10, 4'h0, 3, "R5 buffer A");
    do_read(0, 8'hB2, 9, 200, 4'h5, 3, "R5 buffer B");
    do_read(0, 8'hA1, 2047, 262, 4'h0, 4, "R6 last page wrap");
    do_read(0, 8'hA1, 100, 261, 4'h0, 4, "R6 page carry");
    do_read(0, 8'hA1, 40, 300, 4'h0, 3, "R6 offset beyond page");
    do_read(0, 8'hB1, 3, 261, 4'h0, 5, "R7 buffer A wrap");
    do_read(1, 8'hB2, 0, 262, 4'h0, 3, "R7 buffer B wrap");
    do_read(1, 8'hA1, 5, 0, 4'h0, 3, "R8 idle-high clock");
    do_read(1, 8'hB1, 0, 10, 4'hA, 2, "R8 idle-high buffer");

    r0 = rd_cnt;
    begin_cmd(0);
    send(32'h3C, 8);
    send($urandom, 24);
    send($urandom, 16);
    end_cmd();
    chk(cmd_oe_seen == 0, "R11 no drive", cmd_oe_seen, 0);
    chk(rd_cnt == r0, "R11 no request", rd_cnt - r0, 0);

    r0 = rd_cnt;
    begin_cmd(0);
    send(32'hA1, 8);
    send(32'h3FF, 10);
    end_cmd();
    chk(so_oe == 0, "R10 abort in address", so_oe, 0);
    chk(rd_cnt == r0, "R10 no request after abort", rd_cnt - r0, 0);
    do_read(0, 8'hA1, 600, 20, 4'h0, 2, "R10 restart after address abort");

    begin_cmd(1);
    send(32'hB2, 8);
    send(32'd50, 24);
    in_data = 1;
    send($urandom, 3);
    chk(last_oe == 1, "R9 drive mid byte", last_oe, 1);
    end_cmd();
    in_data = 0;
    chk(so_oe == 0, "R10 abort in data", so_oe, 0);
    do_read(0, 8'hB2, 0, 51, 4'h0, 2, "R10 restart after data abort");

    for (int t = 0; t < 24; t++) begin
      logic [7:0] op;
      int sel;
      sel = $urandom % 3;
      op = (sel == 0) ? 8'hA1 : (sel == 1) ? 8'hB1 : 8'hB2;
      do_read(1'($urandom), op, $urandom % 2048, $urandom % 264, 4'($urandom),
              1 + $urandom % 5, "R2 random command");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule